// File: doc/BRIEF.md
# Predicated Contiguous Doubleword Store Sequencer

This block turns one already-decoded-ready store instruction into a sequence of 64-bit memory writes. It accepts a 32-bit instruction word together with operand values that were read from the register files earlier in the pipeline: a 64-bit base, a 64-bit index, a vector of `VL` bits and a predicate of `VL/8` bits (one bit per vector byte). It checks the instruction word for one of two element-size forms: 64-bit elements, or 128-bit elements of which only the low doubleword is stored. A word that matches neither form is reported as not decoded.

For a valid instruction the block walks the element slots in ascending order. The address starts at base plus eight times the index and moves on by 8 bytes per slot. Each slot whose predicate bit is set produces one write request on a valid/ready port. Slots whose bit is clear are skipped, but they still move the address on. The instruction can name the stack pointer as its base. In that case, if the stack pointer is not 16-byte aligned and at least one element is active, the block reports an alignment fault and issues no writes. Completion is a single-cycle `done` pulse that carries the not-decoded and fault flags.

Top module: `pvst_sequencer`

## Requirements
- R1: The block accepts a word as a store when bits 31:21 are 11100101111 (64-bit element form) or 11100101110 (128-bit element form), bits 15:13 are 010 and the Rm field in bits 20:16 is not 11111. The base register number sits in bits 9:5.
- R2: Any other word completes with `done` and `done_undef` high one cycle after acceptance and issues no write.
- R3: The first slot's address is base + index*8, taken modulo 2^64.
- R4: The address grows by 8 for every slot, whether or not that slot is written.
- R5: Slot e is active when predicate bit e*esize/8 is 1 (bit 8e for the 64-bit form, bit 16e for the 128-bit form). Inactive slots issue no write, and the other predicate bits have no effect.
- R6: The 64-bit form walks VL/64 slots and stores element e whole. The 128-bit form walks VL/128 slots and stores bits 128e+63:128e of the vector.
- R7: Writes are issued in ascending slot order, one request per active slot.
- R8: When the base register number is 31, at least one slot is active and base bits 3:0 are not all zero, the block completes one cycle after acceptance with `done_fault` high and issues no write.
- R9: When no slot is active, the block issues no write, raises no fault (even with a misaligned stack-pointer base) and completes one cycle after acceptance.
- R10: A write request keeps `wr_valid`, `wr_addr` and `wr_data` unchanged until `wr_ready` is sampled high.
- R11: `done` is a single-cycle pulse that follows the last slot, and `in_ready` is high only while the block is idle.
- R12: After reset `in_ready` is 1 and `wr_valid`, `done`, `done_undef` and `done_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are offered |
| in_ready | output | 1 | Block is idle and takes the offer |
| insn | input | 32 | Instruction word |
| base_val | input | 64 | Base register or stack pointer value |
| index_val | input | 64 | Index register value |
| vec_val | input | VL | Source vector |
| pred_val | input | VL/8 | Governing predicate, one bit per byte |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory side takes the write |
| wr_addr | output | 64 | Write byte address |
| wr_data | output | 64 | Write data |
| done | output | 1 | Single-cycle completion pulse |
| done_undef | output | 1 | With done: word was not decoded |
| done_fault | output | 1 | With done: stack-pointer alignment fault |

## Verification
The bench runs every predicate pattern over the slot bits of both forms, at a plain base, at a base and index whose sum wraps past 2^64, and with a stack-pointer base. The predicate bits that sit between slot positions are always set to one, so a design that reads the wrong bit or the wrong granularity produces extra writes. The memory side stalls in a pseudo-random pattern, which separates correct holding of a request from a request that moves or drops while stalled. Separate cases use a reserved Rm field, a wrong fixed field, a wrong opcode, a misaligned stack pointer with and without active slots, and a misaligned ordinary base. These cases tell apart the decode rejection, the fault, the empty completion and normal writes.

// File: rtl/pvst_pkg.sv
// Shared constants and types for the predicated contiguous store sequencer.
// Assumes: instruction field positions are fixed by the encoding and are not
// parameters.
package pvst_pkg;
    localparam logic [10:0] OPC_ELEM64  = 11'b11100101111;
    localparam logic [10:0] OPC_ELEM128 = 11'b11100101110;
    localparam logic [2:0]  FIXED_BITS  = 3'b010;
    localparam logic [4:0]  RM_RESERVED = 5'b11111;
    localparam logic [4:0]  REG_SP      = 5'd31;
    localparam int          DW_BYTES    = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } pvst_state_e;
endpackage

// File: rtl/pvst_decode.sv
// Recognises the two element-size forms of the store word.
// Assumes: insn_hi holds instruction bits 31:13 and rn holds bits 9:5.
module pvst_decode
    import pvst_pkg::*;
(
    input  logic [18:0] insn_hi,
    input  logic [4:0]  rn,
    output logic        legal,
    output logic        q128,
    output logic        rn_is_sp
);
    logic [10:0] opc;
    logic [4:0]  rm;
    logic [2:0]  fixed;
    logic        hit64, hit128;

    // Split the upper fields and compare them with both forms.
    always_comb begin
        opc      = insn_hi[18:8];
        rm       = insn_hi[7:3];
        fixed    = insn_hi[2:0];
        hit64    = (opc == OPC_ELEM64);
        hit128   = (opc == OPC_ELEM128);
        legal    = (hit64 || hit128) && (fixed == FIXED_BITS) && (rm != RM_RESERVED);
        q128     = hit128;
        rn_is_sp = (rn == REG_SP);
    end
endmodule

// File: rtl/pvst_any_active.sv
// Reports whether any element slot is active for the form being decoded.
// Assumes: a slot is NSLOT-th of the vector (64 bits); in the 128-bit form only
// even slots are element starts.
module pvst_any_active #(
    parameter int NSLOT = 4,
    localparam int PW = NSLOT * 8
) (
    input  logic [PW-1:0] pred,
    input  logic          q128,
    output logic          any
);
    logic [NSLOT-1:0] slot_bit;
    logic [NSLOT-1:0] even_mask;
    logic             unused_pred;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_bit[s]  = pred[s*8];
        assign even_mask[s] = ((s % 2) == 0);
    end

    assign unused_pred = ^pred;

    // Pick the slot starts that belong to the decoded form.
    always_comb begin
        any = q128 ? |(slot_bit & even_mask) : |slot_bit;
    end
endmodule

// File: rtl/pvst_slot_pick.sv
// Selects the predicate bit and low doubleword of the element at index idx.
// Assumes: idx never exceeds the last element of the latched form.
module pvst_slot_pick #(
    parameter int NSLOT = 4,
    localparam int VW = NSLOT * 64,
    localparam int PW = NSLOT * 8,
    localparam int IW = $clog2(NSLOT)
) (
    input  logic [VW-1:0] vec,
    input  logic [PW-1:0] pred,
    input  logic          q128,
    input  logic [IW-1:0] idx,
    output logic          active,
    output logic [63:0]   data,
    output logic          last
);
    logic [63:0]      slot_data [NSLOT];
    logic [NSLOT-1:0] slot_bit;
    logic [IW-1:0]    slot;
    logic             unused_pred;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        assign slot_data[s] = vec[s*64 +: 64];
        assign slot_bit[s]  = pred[s*8];
    end

    assign unused_pred = ^pred;

    // Map element index to 64-bit slot and detect the final element.
    always_comb begin
        slot   = q128 ? IW'(idx << 1) : idx;
        active = slot_bit[slot];
        data   = slot_data[slot];
        last   = q128 ? (idx == IW'(NSLOT/2 - 1)) : (idx == IW'(NSLOT - 1));
    end
endmodule

// File: rtl/pvst_walker.sv
// Control state machine: starts a walk on acceptance, steps the element index
// and address, and pulses done with the completion flags.
// Assumes: slot_active/slot_last describe the element at idx.
module pvst_walker
    import pvst_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          legal,
    input  logic          fault_now,
    input  logic          any_active,
    input  logic [63:0]   start_addr,
    input  logic          slot_active,
    input  logic          slot_last,
    input  logic          wr_ready,
    output logic          idle,
    output logic [IW-1:0] idx,
    output logic [63:0]   addr,
    output logic          wr_valid,
    output logic          done,
    output logic          done_undef,
    output logic          done_fault
);
    pvst_state_e state;
    logic        undef_q, fault_q;
    logic        running, adv;

    // Derive handshake and step condition from the current state.
    always_comb begin
        running    = (state == ST_RUN);
        idle       = (state == ST_IDLE);
        wr_valid   = running && slot_active;
        adv        = running && (slot_active ? wr_ready : 1'b1);
        done       = (state == ST_FIN);
        done_undef = done && undef_q;
        done_fault = done && fault_q;
    end

    // State, element index and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            addr    <= '0;
            undef_q <= 1'b0;
            fault_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    idx     <= '0;
                    addr    <= start_addr;
                    undef_q <= !legal;
                    fault_q <= legal && fault_now;
                    state   <= (!legal || fault_now || !any_active) ? ST_FIN : ST_RUN;
                end
                ST_RUN: if (adv) begin
                    idx  <= idx + IW'(1);
                    addr <= addr + 64'(DW_BYTES);
                    if (slot_last) state <= ST_FIN;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(addr)));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !slot_last) |=> (addr == $past(addr) + 64'(DW_BYTES)));
endmodule

// File: rtl/pvst_sequencer.sv
// Top of the predicated contiguous doubleword store sequencer. Decodes the
// word, checks the stack-pointer alignment, latches the operands and drives
// one write per active element.
// Assumes: VL is a multiple of 128 and at least 128; operands are valid with
// in_valid.
module pvst_sequencer
    import pvst_pkg::*;
#(
    parameter int VL = 256,
    parameter int SP_ALIGN_BITS = 4,
    localparam int PW = VL / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [31:0]   insn,
    input  logic [63:0]   base_val,
    input  logic [63:0]   index_val,
    input  logic [VL-1:0] vec_val,
    input  logic [PW-1:0] pred_val,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [63:0]   wr_addr,
    output logic [63:0]   wr_data,
    output logic          done,
    output logic          done_undef,
    output logic          done_fault
);
    localparam int NSLOT = VL / 64;
    localparam int IW    = $clog2(NSLOT);

    logic          dec_legal, dec_q128, dec_rn_sp;
    logic          in_any, accept, fault_now, idle;
    logic [63:0]   start_addr;
    logic [VL-1:0] vec_q;
    logic [PW-1:0] pred_q;
    logic          q128_q;
    logic [IW-1:0] idx;
    logic          slot_active, slot_last;
    logic          unused_fields;

    assign unused_fields = ^{insn[12:10], insn[4:0]};

    pvst_decode u_dec (
        .insn_hi  (insn[31:13]),
        .rn       (insn[9:5]),
        .legal    (dec_legal),
        .q128     (dec_q128),
        .rn_is_sp (dec_rn_sp)
    );

    pvst_any_active #(.NSLOT(NSLOT)) u_any (
        .pred (pred_val),
        .q128 (dec_q128),
        .any  (in_any)
    );

    // Acceptance, alignment fault and first address.
    always_comb begin
        in_ready   = idle;
        accept     = in_valid && idle;
        fault_now  = dec_rn_sp && in_any && (base_val[SP_ALIGN_BITS-1:0] != '0);
        start_addr = base_val + (index_val << 3);
    end

    // Latch the operands for the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            pred_q <= '0;
            q128_q <= 1'b0;
        end else if (accept) begin
            vec_q  <= vec_val;
            pred_q <= pred_val;
            q128_q <= dec_q128;
        end
    end

    pvst_slot_pick #(.NSLOT(NSLOT)) u_pick (
        .vec    (vec_q),
        .pred   (pred_q),
        .q128   (q128_q),
        .idx    (idx),
        .active (slot_active),
        .data   (wr_data),
        .last   (slot_last)
    );

    pvst_walker #(.IW(IW)) u_walk (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .legal       (dec_legal),
        .fault_now   (fault_now),
        .any_active  (in_any),
        .start_addr  (start_addr),
        .slot_active (slot_active),
        .slot_last   (slot_last),
        .wr_ready    (wr_ready),
        .idle        (idle),
        .idx         (idx),
        .addr        (wr_addr),
        .wr_valid    (wr_valid),
        .done        (done),
        .done_undef  (done_undef),
        .done_fault  (done_fault)
    );

    // R10
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> $stable(wr_data));

    // R2 R8
    early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (done_undef || done_fault)) |-> $past(accept));

    // R11
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || done) |-> !in_ready);
endmodule

// File: tb/test_pvst_sequencer.sv
module test_pvst_sequencer;
    localparam int VL = 256;
    localparam int PW = VL / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [31:0]   insn = '0;
    logic [63:0]   base_val = '0, index_val = '0;
    logic [VL-1:0] vec_val = '0;
    logic [PW-1:0] pred_val = '0;
    logic          wr_valid, wr_ready = 1'b0;
    logic [63:0]   wr_addr, wr_data;
    logic          done, done_undef, done_fault;

    int n_chk = 0, n_bad = 0;
    logic [63:0] got_addr [16];
    logic [63:0] got_data [16];
    int          got_n = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        hold_pend = 1'b0;
    logic [63:0] hold_addr, hold_data;

    always #2 clk = ~clk;

    pvst_sequencer #(.VL(VL)) i_pvst_sequencer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .insn(insn), .base_val(base_val), .index_val(index_val),
        .vec_val(vec_val), .pred_val(pred_val), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .done_undef(done_undef), .done_fault(done_fault)
    );

    // Memory side: pseudo-random ready, write capture and hold check (R10).
    always @(negedge clk) begin
        logic rdy;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        rdy = lfsr[0] | lfsr[3];
        if (hold_pend) begin
            n_chk++;
            if (!wr_valid || wr_addr != hold_addr || wr_data != hold_data) begin
                n_bad++;
                $display("FAIL R10 held request moved: got v=%0b a=%0h d=%0h exp a=%0h d=%0h",
                         wr_valid, wr_addr, wr_data, hold_addr, hold_data);
            end
        end
        hold_pend = wr_valid && !rdy;
        hold_addr = wr_addr;
        hold_data = wr_data;
        wr_ready <= rdy;
        if (wr_valid && rdy && got_n < 16) begin
            got_addr[got_n] = wr_addr;
            got_data[got_n] = wr_data;
            got_n++;
        end
    end

    function automatic logic [31:0] mk_insn(input bit q128, input logic [4:0] rm,
                                            input logic [4:0] rn);
        return {10'b1110010111, ~q128, rm, 3'b010, 3'd2, rn, 5'd7};
    endfunction

    function automatic logic [VL-1:0] mk_vec(input int seed);
        logic [VL-1:0] v;
        for (int s = 0; s < VL/64; s++)
            v[s*64 +: 64] = {32'(seed) * 32'h9E37_79B9, 16'hC0DE, 16'(s)};
        return v;
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] got,
                         input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h exp %0h", req, what, got, exp);
        end
    endtask

    // Drive one instruction, wait for done, compare writes and flags.
    task automatic run_op(input string req, input logic [31:0] ins, input logic [63:0] b,
                          input logic [63:0] x, input logic [VL-1:0] v,
                          input logic [PW-1:0] p, input bit e_undef, input bit e_fault);
        bit          q128 = !ins[21];
        int          nel = q128 ? VL/128 : VL/64;
        int          nexp = 0;
        logic [63:0] ea [16];
        logic [63:0] ed [16];
        int          cyc = 0;
        if (!e_undef && !e_fault) begin
            for (int e = 0; e < nel; e++) begin
                int slot = q128 ? 2*e : e;
                if (p[slot*8]) begin
                    ea[nexp] = b + x*64'd8 + 64'(8*e);
                    ed[nexp] = v[slot*64 +: 64];
                    nexp++;
                end
            end
        end
        @(negedge clk);
        got_n = 0;
        insn = ins; base_val = b; index_val = x; vec_val = v; pred_val = p;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check(req, "done seen", 64'(done), 64'd1);
        check(e_undef ? "R2" : "R1", "undef flag", 64'(done_undef), 64'(e_undef));
        check("R8", "fault flag", 64'(done_fault), 64'(e_fault));
        if (nexp == 0) check(e_undef ? "R2" : (e_fault ? "R8" : "R9"), "latency", 64'(cyc), 64'd1);
        check("R7", "write count", 64'(got_n), 64'(nexp));
        for (int i = 0; i < nexp && i < got_n; i++) begin
            check(i == 0 ? "R3" : "R4", "address", got_addr[i], ea[i]);
            check(q128 ? "R6" : "R5", "data", got_data[i], ed[i]);
        end
        @(negedge clk);
        check("R11", "done pulse ends", 64'(done), 64'd0);
        check("R11", "ready after done", 64'(in_ready), 64'd1);
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired: got running exp finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] bases [3];
        logic [63:0] idxs [3];
        logic [4:0]  rns [3];
        bases[0] = 64'h1000;                idxs[0] = 64'd3;                  rns[0] = 5'd5;
        bases[1] = 64'hFFFF_FFFF_FFFF_FFF0; idxs[1] = 64'd4;                  rns[1] = 5'd31;
        bases[2] = 64'h8;                   idxs[2] = 64'hFFFF_FFFF_FFFF_FFFF; rns[2] = 5'd9;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12
        check("R12", "in_ready", 64'(in_ready), 64'd1);
        check("R12", "wr_valid", 64'(wr_valid), 64'd0);
        check("R12", "done", 64'(done), 64'd0);
        check("R12", "flags", 64'({done_undef, done_fault}), 64'd0);

        // R5 R7: 64-bit form, all slot patterns, off-slot predicate bits set.
        for (int k = 0; k < 3; k++) begin
            for (int pat = 0; pat < 16; pat++) begin
                logic [PW-1:0] p = 32'hFEFE_FEFE;
                for (int s = 0; s < 4; s++) p[s*8] = pat[s];
                run_op("R5", mk_insn(1'b0, 5'd3, rns[k]), bases[k], idxs[k],
                       mk_vec(k*16 + pat), p, 1'b0, 1'b0);
            end
        end
        // R6: 128-bit form, odd-slot start bits set as noise.
        for (int k = 0; k < 3; k++) begin
            for (int pat = 0; pat < 4; pat++) begin
                logic [PW-1:0] p = 32'hFFFE_FFFE;
                p[0] = pat[0]; p[16] = pat[1];
                run_op("R6", mk_insn(1'b1, 5'd12, rns[k]), bases[k], idxs[k],
                       mk_vec(100 + k*4 + pat), p, 1'b0, 1'b0);
            end
        end
        // R2: reserved Rm, wrong fixed field, wrong opcode.
        run_op("R2", mk_insn(1'b0, 5'd31, 5'd5), 64'h2000, 64'd1, mk_vec(1), '1, 1'b1, 1'b0);
        run_op("R2", mk_insn(1'b1, 5'd31, 5'd5), 64'h2000, 64'd1, mk_vec(2), '1, 1'b1, 1'b0);
        run_op("R2", mk_insn(1'b0, 5'd2, 5'd5) ^ 32'h0000_2000, 64'h2000, 64'd1, mk_vec(3), '1, 1'b1, 1'b0);
        run_op("R2", mk_insn(1'b0, 5'd2, 5'd5) ^ 32'h0080_0000, 64'h2000, 64'd1, mk_vec(4), '1, 1'b1, 1'b0);
        // R8: misaligned stack pointer with active slots, both forms.
        run_op("R8", mk_insn(1'b0, 5'd2, 5'd31), 64'h1004, 64'd0, mk_vec(5), 32'h0000_0100, 1'b0, 1'b1);
        run_op("R8", mk_insn(1'b1, 5'd2, 5'd31), 64'h1008, 64'd0, mk_vec(6), 32'h0001_0000, 1'b0, 1'b1);
        // R9: misaligned stack pointer with no active slot: no fault, no writes.
        run_op("R9", mk_insn(1'b0, 5'd2, 5'd31), 64'h1004, 64'd0, mk_vec(7), 32'hFEFE_FEFE, 1'b0, 1'b0);
        run_op("R9", mk_insn(1'b1, 5'd2, 5'd31), 64'h1004, 64'd0, mk_vec(8), 32'hFFFE_FFFE, 1'b0, 1'b0);
        // R8: misaligned ordinary base is not checked.
        run_op("R8", mk_insn(1'b0, 5'd2, 5'd30), 64'h1004, 64'd2, mk_vec(9), 32'h0101_0101, 1'b0, 1'b0);
        // R1: aligned stack pointer writes normally.
        run_op("R1", mk_insn(1'b0, 5'd0, 5'd31), 64'h1010, 64'd0, mk_vec(10), 32'h0100_0001, 1'b0, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule